// File: doc/BRIEF.md
# Striped Address Node Mapper

This block turns a 64-bit virtual address into the number of the node that owns it and an offset inside that node's memory. It uses no translation table. The six most significant address bits give a bit position. The node number is read from the lower address bits starting at that position. Each address therefore picks its own striping granularity, which can be any power of two. All bytes below the chosen position stay together on one node.

The block also produces a compacted local address. It is built from the bits below the node field and the bits above it, with the node field removed, so the local space has no holes. A flag reports whether the owning node is this node, by comparing the node number against a static identifier input. A second flag reports a position that leaves no room for the node field. The result is registered one cycle after a valid strobe and is held until the next strobe.

Top module: `stripe_node_map`

## Requirements
- R1: While rst_n is low, and after reset until the first accepted address, out_valid, out_node, out_local, out_is_local and out_err are all zero.
- R2: out_valid is high in the cycle after each cycle in which in_valid was high, and low otherwise.
- R3: For a position k = in_addr[63:58] with k <= 58-NODE_W (48 by default), out_node equals in_addr[k+NODE_W-1:k].
- R4: For a legal k, out_local holds in_addr[k-1:0] in its low k bits. Above those, in order, it holds in_addr[57:k+NODE_W]. Its remaining top bits are zero. Bits 63:58 never reach out_local.
- R5: out_is_local is high exactly when the accepted address is legal and out_node equals self_id.
- R6: When k > 58-NODE_W, out_err is high and out_node, out_local and out_is_local are zero. For a legal k, out_err is low.
- R7: In a cycle with in_valid low, out_node, out_local, out_is_local and out_err keep their values, whatever in_addr carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | NODE_W | Static identifier of this node |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 64 | Virtual address; bits 63:58 give the field position |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_node | output | NODE_W | Owning node number |
| out_local | output | 58-NODE_W | Compacted address inside the owning node |
| out_is_local | output | 1 | Owning node equals self_id |
| out_err | output | 1 | Node field would extend past bit 57 |

## Verification
The bench visits every one of the 64 position values with several bit patterns. This covers position 0, where nothing lies below the field, and position 48, where nothing lies above it. If the design mishandled these edges, it would drop or duplicate a local bit, or take a node bit from the position field. Positions 49 through 63 must raise the error flag and clear the outputs. An off-by-one bound would instead wrap the field into the position bits or wrongly reject position 48. Each position is also given an address whose node field equals self_id, to exercise the local flag. Between strobes the bench changes the address, and a design that failed to hold its outputs would follow it.

// File: rtl/stripe_node_map.sv
module stripe_node_map #(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 6,
  parameter int NODE_W = 10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NODE_W-1:0]                   self_id,
  input  logic                                in_valid,
  input  logic [ADDR_W-1:0]                   in_addr,
  output logic                                out_valid,
  output logic [NODE_W-1:0]                   out_node,
  output logic [ADDR_W-SEL_W-NODE_W-1:0]      out_local,
  output logic                                out_is_local,
  output logic                                out_err
);
  localparam int LOW_W   = ADDR_W - SEL_W;
  localparam int LOC_W   = LOW_W - NODE_W;
  localparam int MAX_POS = LOW_W - NODE_W;

  logic [SEL_W-1:0]  pos;
  logic [LOW_W-1:0]  low;
  logic [LOW_W-1:0]  keep_mask;
  logic              bad;
  logic [NODE_W-1:0] node_n;
  logic [LOC_W-1:0]  loc_n;

  assign pos       = in_addr[ADDR_W-1 -: SEL_W];
  assign low       = in_addr[LOW_W-1:0];
  assign bad       = int'(pos) > MAX_POS;
  assign keep_mask = ~({LOW_W{1'b1}} << pos);
  assign node_n    = NODE_W'(low >> pos);
  assign loc_n     = LOC_W'((low & keep_mask) | ((low >> NODE_W) & ~keep_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_node     <= '0;
      out_local    <= '0;
      out_is_local <= 1'b0;
      out_err      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err      <= bad;
        out_node     <= bad ? '0 : node_n;
        out_local    <= bad ? '0 : loc_n;
        out_is_local <= !bad && (node_n == self_id);
      end
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_local |-> (out_node == self_id && !out_err));
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_node == '0 && out_local == '0 && !out_is_local));
  assert_err_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_err == (int'($past(in_addr[ADDR_W-1 -: SEL_W])) > MAX_POS)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_node) && $stable(out_local) && $stable(out_err)
                   && $stable(out_is_local)));
endmodule

// File: tb/stripe_node_map_tb.sv
`timescale 1ns/1ps
module stripe_node_map_tb;
  localparam int NODE_W = 10;
  localparam int LOC_W  = 48;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [NODE_W-1:0] self_id = 10'h2A5;
  logic              in_valid = 0;
  logic [63:0]       in_addr = '0;
  logic              out_valid;
  logic [NODE_W-1:0] out_node;
  logic [LOC_W-1:0]  out_local;
  logic              out_is_local;
  logic              out_err;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stripe_node_map u_dut (
    .clk(clk), .rst_n(rst_n), .self_id(self_id), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_node(out_node),
    .out_local(out_local), .out_is_local(out_is_local), .out_err(out_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, in_addr);
    end
  endtask

  task automatic apply(input logic [63:0] a);
    int k;
    int j;
    logic [NODE_W-1:0] en;
    logic [LOC_W-1:0] el;
    logic eerr;
    k = int'(a[63:58]);
    eerr = k > 48;
    en = '0;
    el = '0;
    if (!eerr) begin
      for (int i = 0; i < NODE_W; i++) en[i] = a[k+i];
      j = 0;
      for (int b = 0; b < 58; b++)
        if (b < k || b >= k + NODE_W) begin
          el[j] = a[b];
          j++;
        end
    end
    @(negedge clk);
    in_valid = 1;
    in_addr = a;
    @(negedge clk);
    in_valid = 0;
    in_addr = ~a;
    check("R2 valid", 64'(out_valid), 64'd1);
    check("R6 err", 64'(out_err), 64'(eerr));
    check("R3 node", 64'(out_node), 64'(en));
    check("R4 local", 64'(out_local), 64'(el));
    check("R5 is_local", 64'(out_is_local), 64'(!eerr && en == self_id));
    @(negedge clk);
    check("R2 idle", 64'(out_valid), 64'd0);
    check("R7 hold node", 64'(out_node), 64'(en));
    check("R7 hold local", 64'(out_local), 64'(el));
    check("R7 hold err", 64'(out_err), 64'(eerr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 node", 64'(out_node), 64'd0);
    check("R1 local", 64'(out_local), 64'd0);
    check("R1 flags", 64'({out_is_local, out_err}), 64'd0);
    rst_n = 1;
    in_addr = '1;
    @(negedge clk);
    check("R1 after release", 64'({out_valid, out_err}), 64'd0);
    for (int k = 0; k < 64; k++) begin
      logic [63:0] m;
      m = {k[5:0], 58'h0};
      apply(m | 64'h03FF_FFFF_FFFF_FFFF);
      apply(m);
      apply(m | 64'h0155_5555_5555_5555);
      apply(m | (58'({$urandom, $urandom})));
      if (k <= 48) apply(m | (58'(self_id) << k) | 58'h1);
      else apply(m | 58'(self_id));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule